// File: doc/BRIEF.md
# Stereo Soft Mute and Silence Detector

This block sits between a stereo sample source and a DAC modulator and works only on digital samples. On every strobed frame it takes a signed left and right sample and scales both by a shared gain. When the mute request is high, the gain steps down toward silence once per frame. When the request is low, the gain steps back up toward unity once per frame. Because the ramp steps from wherever it is, a request that toggles mid-ramp reverses the ramp from its current level.

Alongside the gain path, a run counter watches both input channels. When both channels have held exactly zero for a long unbroken run of frames, a silence flag goes high. The first frame with any nonzero sample on either channel clears the flag and restarts the count. Cycles without a frame strobe neither advance nor break the run.

Top module: `audio_softmute`

## Requirements
- R1: Synchronous active-high reset sets the gain to unity (1024), the zero-run count to 0, and drives `out_valid`, `silence`, `out_left` and `out_right` to 0.
- R2: `out_valid` equals `in_valid` delayed by one clock; `out_left`/`out_right` change only on the clock after a strobed frame and hold otherwise.
- R3: Each output sample is floor(input × g / 1024), where g is the gain held before that frame's step, so the first muted frame is still output at the old gain.
- R4: On a strobed frame with `mute_req` high the gain drops by one, stopping at 0; at gain 0 both outputs are exactly 0, reached after 1024 muted frames from unity.
- R5: On a strobed frame with `mute_req` low the gain rises by one, stopping at 1024; at gain 1024 outputs equal inputs bit for bit.
- R6: Releasing the request after k muted frames from unity (k < 1024) brings the gain back to unity after exactly k unmuted frames.
- R7: On cycles with `in_valid` low, `mute_req` and the sample inputs are ignored: the gain and the zero-run count do not change.
- R8: `silence` rises on the output of the 8192nd consecutive strobed frame in which both channels are zero, and not earlier.
- R9: A strobed frame with either channel nonzero drives `silence` low on that frame's output and restarts the run; one zero channel alone never advances it.
- R10: The zero-run count saturates at 8192, so `silence` stays high through any longer all-zero run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Frame strobe, one per sample frame |
| mute_req | input | 1 | Mute request, sampled on strobed frames |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| out_valid | output | 1 | Output frame strobe |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| silence | output | 1 | High after a long both-zero run |

## Verification
On every cycle, the assertions check that the gain steps by one per strobed frame in the requested direction and is frozen between frames. They also check that the output strobe trails the input strobe, that zero gain gives silence and unity gain gives bit-exact samples, that a nonzero frame clears the flag, and that the run count never passes its limit. Other properties need long scenarios and can only be shown by the bench: the exact frame on which the flag rises, ramp reversal from an intermediate level, floor rounding of negative samples, and holding across strobe gaps. The bench's per-clock reference model covers these.

// File: rtl/softmute_pkg.sv
package softmute_pkg;
  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_DOWN = 2'd1,
    RAMP_UP   = 2'd2
  } ramp_dir_e;
endpackage

// File: rtl/gain_ramp.sv
module gain_ramp
  import softmute_pkg::*;
#(
  parameter int UNITY = 1024,
  localparam int GW = $clog2(UNITY) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_en,
  input  logic          mute,
  output logic [GW-1:0] gain,
  output ramp_dir_e     dir
);
  localparam logic [GW-1:0] G_TOP = GW'(UNITY);

  always_comb begin
    dir = RAMP_HOLD;
    if (step_en) begin
      if (mute && gain != '0)        dir = RAMP_DOWN;
      else if (!mute && gain != G_TOP) dir = RAMP_UP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain <= G_TOP;
    end else begin
      case (dir)
        RAMP_DOWN: gain <= gain - 1'b1;
        RAMP_UP:   gain <= gain + 1'b1;
        default:   gain <= gain;
      endcase
    end
  end
endmodule

// File: rtl/sample_scaler.sv
module sample_scaler #(
  parameter int DW = 24,
  parameter int GW = 11,
  parameter int SHIFT = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] din,
  input  logic [GW-1:0]        gain,
  output logic signed [DW-1:0] dout
);
  localparam int PW = DW + GW + 1;

  function automatic logic signed [DW-1:0] apply_gain(
    input logic signed [DW-1:0] s,
    input logic [GW-1:0]        g
  );
    logic signed [PW-1:0] se, ge, prod, sh;
    se   = PW'(s);
    ge   = PW'($signed({1'b0, g}));
    prod = se * ge;
    sh   = prod >>> SHIFT;
    return sh[DW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst)     dout <= '0;
    else if (en) dout <= apply_gain(din, gain);
  end
endmodule

// File: rtl/zero_run_detect.sv
module zero_run_detect #(
  parameter int RUN_LEN = 8192,
  localparam int CW = $clog2(RUN_LEN) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          both_zero,
  output logic          flag,
  output logic [CW-1:0] run_cnt,
  output logic          zero_hit
);
  localparam logic [CW-1:0] RUN_FULL = CW'(RUN_LEN);
  localparam logic [CW-1:0] RUN_LAST = CW'(RUN_LEN - 1);

  assign zero_hit = en && both_zero && (run_cnt == RUN_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      flag    <= 1'b0;
    end else if (en) begin
      if (both_zero) begin
        if (run_cnt != RUN_FULL) run_cnt <= run_cnt + 1'b1;
        flag <= (run_cnt >= RUN_LAST);
      end else begin
        run_cnt <= '0;
        flag    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/audio_softmute.sv
module audio_softmute
  import softmute_pkg::*;
#(
  parameter int DW = 24,
  parameter int UNITY = 1024,
  parameter int RUN_LEN = 8192
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 mute_req,
  input  logic signed [DW-1:0] in_left,
  input  logic signed [DW-1:0] in_right,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_left,
  output logic signed [DW-1:0] out_right,
  output logic                 silence
);
  localparam int GW = $clog2(UNITY) + 1;
  localparam int SHIFT = $clog2(UNITY);
  localparam int CW = $clog2(RUN_LEN) + 1;
  localparam int NCH = 2;

  logic [GW-1:0]        gain;
  ramp_dir_e            ramp_dir;
  logic [CW-1:0]        run_cnt;
  logic                 zero_hit;
  logic                 both_zero;
  logic signed [DW-1:0] ch_in  [NCH];
  logic signed [DW-1:0] ch_out [NCH];

  assign ch_in[0]  = in_left;
  assign ch_in[1]  = in_right;
  assign out_left  = ch_out[0];
  assign out_right = ch_out[1];
  assign both_zero = (in_left == '0) && (in_right == '0);

  gain_ramp #(.UNITY(UNITY)) u_ramp (
    .clk(clk), .rst(rst), .step_en(in_valid), .mute(mute_req),
    .gain(gain), .dir(ramp_dir)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sample_scaler #(.DW(DW), .GW(GW), .SHIFT(SHIFT)) u_scale (
      .clk(clk), .rst(rst), .en(in_valid), .din(ch_in[c]),
      .gain(gain), .dout(ch_out[c])
    );
  end

  zero_run_detect #(.RUN_LEN(RUN_LEN)) u_zero (
    .clk(clk), .rst(rst), .en(in_valid), .both_zero(both_zero),
    .flag(silence), .run_cnt(run_cnt), .zero_hit(zero_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end
endmodule

// File: rtl/softmute_chk.sv
module softmute_chk #(
  parameter int DW = 24,
  parameter int UNITY = 1024,
  parameter int RUN_LEN = 8192,
  parameter int GW = 11,
  parameter int CW = 14
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 mute_req,
  input logic signed [DW-1:0] in_left,
  input logic signed [DW-1:0] in_right,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_left,
  input logic signed [DW-1:0] out_right,
  input logic                 silence,
  input logic [GW-1:0]        gain,
  input logic [CW-1:0]        run_cnt,
  input logic                 zero_hit
);
  AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (rst) gain <= GW'(UNITY)); // R4
  AST_GAIN_DOWN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mute_req && gain != '0) |=> gain == $past(gain) - 1'b1); // R4
  AST_GAIN_UP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mute_req && gain != GW'(UNITY)) |=> gain == $past(gain) + 1'b1); // R5
  AST_GAIN_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(gain) && $stable(run_cnt)); // R7
  AST_STROBE_ON: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R2
  AST_STROBE_OFF: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(out_left) && $stable(out_right)); // R2
  AST_SILENT_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && gain == '0) |=> out_left == '0 && out_right == '0); // R4
  AST_EXACT_AT_UNITY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && gain == GW'(UNITY)) |=> out_left == $past(in_left) && out_right == $past(in_right)); // R5
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_left != '0 || in_right != '0)) |=> !silence); // R9
  AST_FLAG_RISE: assert property (@(posedge clk) disable iff (rst) zero_hit |=> silence); // R8
  AST_FLAG_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    silence |-> run_cnt == CW'(RUN_LEN)); // R8
  AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (rst) run_cnt <= CW'(RUN_LEN)); // R10
endmodule

bind audio_softmute softmute_chk #(
  .DW(DW), .UNITY(UNITY), .RUN_LEN(RUN_LEN), .GW(GW), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .mute_req(mute_req),
  .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
  .out_left(out_left), .out_right(out_right), .silence(silence),
  .gain(gain), .run_cnt(run_cnt), .zero_hit(zero_hit)
);

// File: tb/audio_softmute_test.sv
module audio_softmute_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic mute_req = 1'b0;
  logic signed [23:0] in_left = '0;
  logic signed [23:0] in_right = '0;
  logic out_valid;
  logic signed [23:0] out_left, out_right;
  logic silence;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  int  m_gain = 1024;
  int  m_run = 0;
  bit  e_valid = 0;
  int  e_left = 0;
  int  e_right = 0;
  bit  e_sil = 0;

  localparam int BIG = 1048576; // 2^20: output = gain * 1024

  always #5 clk = ~clk;

  audio_softmute uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mute_req(mute_req),
    .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right), .silence(silence)
  );

  function automatic int floor_scale(int s, int g);
    longint p, q;
    p = longint'(s) * longint'(g);
    q = p / 1024;
    if (p < 0 && q * 1024 != p) q = q - 1;
    return int'(q);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_gain = 1024; m_run = 0;
      e_valid = 0; e_left = 0; e_right = 0; e_sil = 0;
    end else begin
      e_valid = in_valid;
      if (in_valid) begin
        e_left  = floor_scale(int'(in_left), m_gain);
        e_right = floor_scale(int'(in_right), m_gain);
        if (in_left == 0 && in_right == 0) begin
          e_sil = (m_run + 1 >= 8192);
          if (m_run < 8192) m_run = m_run + 1;
        end else begin
          e_sil = 0;
          m_run = 0;
        end
        if (mute_req) begin
          if (m_gain > 0) m_gain = m_gain - 1;
        end else if (m_gain < 1024) m_gain = m_gain + 1;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model, at the falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 strobe", int'(out_valid), int'(e_valid));
      chk("R3 left", int'(out_left), e_left);
      chk("R3 right", int'(out_right), e_right);
      chk("R8 flag", int'(silence), int'(e_sil));
    end
  end

  task automatic frame(int l, int r, bit m);
    in_valid = 1'b1; mute_req = m;
    in_left = 24'(l); in_right = 24'(r);
    @(negedge clk);
  endtask

  task automatic gap(bit m);
    in_valid = 1'b0; mute_req = m;
    in_left = 24'(12345); in_right = 24'(-777);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 left", int'(out_left), 0);
    chk("R1 flag", int'(silence), 0);
    frame(BIG, -5, 0);
    chk("R1 unity gain", int'(out_left), BIG);
    chk("R5 exact", int'(out_right), -5);
    gap(1);
    chk("R2 hold", int'(out_left), BIG);
    chk("R2 strobe low", int'(out_valid), 0);

    // R6/R7: 300 muted frames with gaps that toggle mute, then release
    for (int i = 0; i < 300; i++) begin
      frame(BIG, i * 37 - 4000, 1);
      if (i % 3 == 0) gap(0);
    end
    frame(BIG, 0, 0);
    chk("R7 gain after 300 down", int'(out_left), (1024 - 300) * 1024);
    for (int i = 0; i < 298; i++) begin
      frame(BIG, 5000 - i, 0);
      if (i % 4 == 0) gap(1);
    end
    frame(BIG, 0, 0);
    chk("R6 one step below unity", int'(out_left), 1023 * 1024);
    frame(BIG, 0, 0);
    chk("R6 back to unity", int'(out_left), BIG);

    // R3: rounding toward minus infinity at gain 512
    for (int i = 0; i < 512; i++) frame(BIG, 3, 1);
    frame(-3, 3, 1);
    chk("R3 negative floor", int'(out_left), -2);
    chk("R3 positive floor", int'(out_right), 1);

    // R4: full mute, silence at extremes
    for (int i = 0; i < 600; i++) frame(BIG, -BIG, 1);
    frame(8388607, -8388608, 1);
    chk("R4 left silent", int'(out_left), 0);
    chk("R4 right silent", int'(out_right), 0);

    // R5: full ramp up
    for (int i = 0; i < 1024; i++) frame(100 + i, -i, 0);
    frame(8388607, -8388608, 0);
    chk("R5 max exact", int'(out_left), 8388607);
    chk("R5 min exact", int'(out_right), -8388608);

    // R8: zero run with gaps
    for (int i = 0; i < 8191; i++) begin
      frame(0, 0, 0);
      if (i % 1000 == 0) gap(0);
    end
    chk("R8 not yet", int'(silence), 0);
    frame(0, 0, 0);
    chk("R8 rises", int'(silence), 1);
    // R10: saturation keeps flag high
    for (int i = 0; i < 900; i++) frame(0, 0, 0);
    chk("R10 stays high", int'(silence), 1);
    // R9: immediate clear
    frame(1, 0, 0);
    chk("R9 clears", int'(silence), 0);
    for (int i = 0; i < 8000; i++) frame(0, 0, 0);
    frame(0, 1, 0);
    chk("R9 restart", int'(silence), 0);
    for (int i = 0; i < 8191; i++) frame(0, 0, 0);
    chk("R9 count restarted", int'(silence), 0);
    frame(0, 0, 0);
    chk("R9 rises after restart", int'(silence), 1);
    for (int i = 0; i < 8300; i++) frame(0, 7, 0);
    chk("R9 one channel insufficient", int'(silence), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule